// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the execute-stage arithmetic and logic unit of a small load/store integer core. Each cycle it takes two 32-bit operands, a 5-bit shift distance and a 4-bit operation code. It produces a 32-bit result and a flag that is high when that result is zero. Any sign or zero extension of immediates is done upstream, so both operands arrive here already 32 bits wide.

The operations are wrapping add and subtract, bitwise AND, OR and NOR, logical shifts left and right, signed and unsigned set-less-than, and upper-half constant placement. NOR is the only inverting primitive: NOR with a zero operand gives a bitwise NOT. Subtracting an immediate is done as an add of a negative sign-extended operand. A 32-bit constant is built in two steps: the upper-half placement, then an OR of the low half.

The outputs are registered. The result and the zero flag for the inputs presented at one rising edge appear after that edge. A synchronous active-high reset clears the result and sets the zero flag. A branch unit uses the zero flag after a subtract to decide equal or not-equal branches.

Top module: `int_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are result 0 and zero flag 1, whatever the other inputs are. Otherwise the result for the inputs sampled at an edge appears on `result`/`zero` right after that edge.
- R2: Code 4'd0 (add) gives A+B modulo 2^32. Carries out of bit 31 are dropped and raise no trap.
- R3: Code 4'd1 (subtract) gives A-B modulo 2^32. A negative difference wraps to its two's-complement pattern.
- R4: Code 4'd2 gives A AND B. Code 4'd3 gives A OR B.
- R5: Code 4'd4 gives NOT(A OR B). With B = 0 this is the bitwise inverse of A.
- R6: Code 4'd5 shifts B left by `shamt` (0 to 31) and fills the low vacated bits with zeros. Operand A has no effect.
- R7: Code 4'd6 shifts B right by `shamt` and fills the high vacated bits with zeros. Operand A has no effect.
- R8: Code 4'd7 (signed less-than) gives 1 when A < B as two's-complement numbers, else 0. Bits 31:1 of the result are always 0. Example: A=0xFFFFFFFF, B=1 gives 1.
- R9: Code 4'd8 (unsigned less-than) gives 1 when A < B as unsigned numbers, else 0, zero-extended in the same way. Example: A=0xFFFFFFFF, B=1 gives 0.
- R10: Code 4'd9 (upper placement) gives B[15:0] in result bits 31:16 and zeros in bits 15:0. Operand A and B[31:16] have no effect.
- R11: `zero` is 1 exactly when `result` is 0, in the same cycle, for every operation.
- R12: Codes 4'd10 to 4'd15 give result 0, and so the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; the value shifted by shifts; source of the upper-placement half |
| shamt | input | 5 | Shift distance for the two shift operations |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered flag, high when `result` is 0 |

## Verification
The zero flag and the result are produced in the same cycle, so every case checks both outputs against one expected value. The cases where the flag must rise are provoked on purpose: subtracting equal operands, an add whose carry wraps to zero, a NOR of all ones, an unsigned compare that comes out false, and every unused code. In each, the flag is judged in the same sample as the zero result. Reset is checked with an add presented at the same edge, to show that reset wins over the arithmetic path.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_LUI  = 4'd9
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd9;
endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
// Shared adder: add, subtract, and both less-than compares from one carry chain.
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         lt_signed,
  output logic         lt_unsigned
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = full[W-1:0];
    // Borrow means A < B unsigned (valid when sub is set).
    lt_unsigned = ~full[W];
    // Differing signs decide directly; equal signs cannot overflow.
    lt_signed = (a[W-1] ^ b[W-1]) ? a[W-1] : full[W-1];
  end
endmodule

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
// Logarithmic logical shifter, one stage per shift-amount bit.
module alu_shifter #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  input  logic           go_left,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stg [0:SHW];

  assign stg[0] = din;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int DIST = 1 << i;
    always_comb begin
      if (!amt[i])
        stg[i+1] = stg[i];
      else if (go_left)
        stg[i+1] = stg[i] << DIST;
      else
        stg[i+1] = stg[i] >> DIST;
    end
  end

  assign dout = stg[SHW];
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
// Bitwise unit: AND, OR and the single inverting primitive, NOR.
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] nor_o
);
  always_comb begin
    and_o = a & b;
    or_o  = a | b;
    nor_o = ~(a | b);
  end
endmodule

// File: rtl/int_alu.sv
`timescale 1ns/1ps
module int_alu
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_sel,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [SHW-1:0]  shamt,
  output logic [W-1:0]    result,
  output logic            zero
);
  localparam int HALF = W / 2;

  logic [W-1:0] sum_w, sh_w, and_w, or_w, nor_w;
  logic         lt_s, lt_u, is_add, is_left;
  logic [W-1:0] nxt_res;

  assign is_add  = (op_sel == OP_ADD);
  assign is_left = (op_sel == OP_SLL);

  alu_addsub #(.W(W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(!is_add),
    .sum(sum_w), .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  alu_shifter #(.W(W), .SHW(SHW)) u_shift (
    .din(opnd_b), .amt(shamt), .go_left(is_left), .dout(sh_w)
  );

  alu_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b), .and_o(and_w), .or_o(or_w), .nor_o(nor_w)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: nxt_res = sum_w;
      OP_AND:         nxt_res = and_w;
      OP_OR:          nxt_res = or_w;
      OP_NOR:         nxt_res = nor_w;
      OP_SLL, OP_SRL: nxt_res = sh_w;
      OP_SLT:         nxt_res = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:        nxt_res = {{(W-1){1'b0}}, lt_u};
      OP_LUI:         nxt_res = {opnd_b[HALF-1:0], {HALF{1'b0}}};
      default:        nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= nxt_res;
      zero   <= (nxt_res == '0);
    end
  end

  // R3 / R11: equal operands on subtract must flag zero for branch-equal.
  a_r3_sub_equal_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SUB && opnd_a == opnd_b) |=> (zero && result == '0));

  // R11: flag and result agree every cycle.
  a_r11_flag_matches: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  // R8 / R9: compares are zero-extended.
  a_r8_compare_extended: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SLT || op_sel == OP_SLTU) |=> (result[W-1:1] == '0));

  // R7: a non-zero right shift always clears the top bit.
  a_r7_srl_top_clear: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SRL && shamt != '0) |=> !result[W-1]);

  // R10: upper placement clears the low half.
  a_r10_lui_low_clear: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_LUI) |=> (result[HALF-1:0] == '0));

  // R12: unused codes give zero.
  a_r12_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel > OP_LAST) |=> (result == '0 && zero));
endmodule

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic [4:0]  shamt;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  int_alu u_int_alu (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .shamt(shamt), .result(result), .zero(zero)
  );

  task automatic check(string tag, logic [31:0] exp_res);
    logic exp_z;
    exp_z = (exp_res == 32'h0);
    checks++;
    if (result !== exp_res || zero !== exp_z) begin
      fails++;
      $display("FAIL %s result=%h expected=%h zero=%b expected=%b",
               tag, result, exp_res, zero, exp_z);
    end
  endtask

  // Drive at a falling edge, let one rising edge register, sample at the next falling edge.
  task automatic run(string tag, logic [3:0] op, logic [31:0] a,
                     logic [31:0] b, logic [4:0] sh, logic [31:0] exp_res);
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
    @(posedge clk);
    @(negedge clk);
    check(tag, exp_res);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; op_sel = 4'd0; opnd_a = 32'd5; opnd_b = 32'd6; shamt = 5'd0;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset beats add", 32'h0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 one-cycle latency after reset", 32'd11);
  endtask

  task automatic t_add;
    run("R2 add carry into sign", 4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h80000000);
    run("R2 R11 add wraps to zero", 4'd0, 32'hFFFFFFFF, 32'h1, 5'd0, 32'h0);
    run("R2 add negative immediate", 4'd0, 32'd10, 32'hFFFFFFFC, 5'd0, 32'd6);
  endtask

  task automatic t_sub;
    run("R3 R11 sub equal", 4'd1, 32'd5, 32'd5, 5'd0, 32'h0);
    run("R3 sub negative", 4'd1, 32'd3, 32'd5, 5'd0, 32'hFFFFFFFE);
    run("R3 sub wrap", 4'd1, 32'h0, 32'h1, 5'd0, 32'hFFFFFFFF);
  endtask

  task automatic t_logic;
    run("R4 and mask", 4'd2, 32'h00003C00, 32'h00000DC0, 5'd0, 32'h00000C00);
    run("R4 or set", 4'd3, 32'h00003C00, 32'h00000DC0, 5'd0, 32'h00003DC0);
    run("R5 nor as not", 4'd4, 32'h00003C00, 32'h0, 5'd0, 32'hFFFFC3FF);
    run("R5 R11 nor all ones", 4'd4, 32'hFFFFFFFF, 32'h0, 5'd0, 32'h0);
    run("R5 nor mixed", 4'd4, 32'h0F0F0000, 32'h000000F0, 5'd0, 32'hF0F0FF0F);
  endtask

  task automatic t_shifts;
    run("R6 sll by 7, A ignored", 4'd5, 32'hDEADBEEF, 32'd5, 5'd7, 32'h00000280);
    run("R6 sll drops top bit", 4'd5, 32'h0, 32'h80000001, 5'd1, 32'h00000002);
    run("R6 sll by 31", 4'd5, 32'h0, 32'h1, 5'd31, 32'h80000000);
    run("R6 sll by 0", 4'd5, 32'hFFFFFFFF, 32'h12345678, 5'd0, 32'h12345678);
    run("R7 srl by 31", 4'd6, 32'hFFFFFFFF, 32'h80000000, 5'd31, 32'h1);
    run("R7 srl zero fill", 4'd6, 32'h0, 32'hF0000000, 5'd4, 32'h0F000000);
    run("R7 srl out to zero", 4'd6, 32'h0, 32'h0000000F, 5'd4, 32'h0);
  endtask

  task automatic t_compare;
    run("R8 slt -1 < 1", 4'd7, 32'hFFFFFFFF, 32'h1, 5'd0, 32'h1);
    run("R8 slt 1 < -1 false", 4'd7, 32'h1, 32'hFFFFFFFF, 5'd0, 32'h0);
    run("R8 slt equal", 4'd7, 32'd5, 32'd5, 5'd0, 32'h0);
    run("R8 slt most negative", 4'd7, 32'h80000000, 32'h7FFFFFFF, 5'd0, 32'h1);
    run("R9 sltu big vs 1", 4'd8, 32'hFFFFFFFF, 32'h1, 5'd0, 32'h0);
    run("R9 sltu 1 vs big", 4'd8, 32'h1, 32'hFFFFFFFF, 5'd0, 32'h1);
    run("R9 sltu equal zero", 4'd8, 32'h0, 32'h0, 5'd0, 32'h0);
  endtask

  task automatic t_upper;
    run("R10 lui ignores A and B high", 4'd9, 32'hFFFFFFFF, 32'h1234ABCD, 5'd3, 32'hABCD0000);
    run("R10 R4 or fills low half", 4'd3, 32'hAAAA0000, 32'h0000EAAB, 5'd0, 32'hAAAAEAAB);
  endtask

  task automatic t_unused;
    for (int k = 10; k < 16; k++)
      run("R12 unused code", 4'(k), 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd9, 32'h0);
  endtask

  initial begin
    rst = 1'b1; op_sel = 4'd0; opnd_a = '0; opnd_b = '0; shamt = '0;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shifts();
    t_compare();
    t_upper();
    t_unused();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired result=%h expected=done zero=%b", result, zero);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule